// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple register bus and the shift logic of an asynchronous serial port. One bus address serves as the character data port. A write there fills a single-entry transmit holding buffer. A read there takes the oldest character out of a two-entry receive queue. A second address returns a status byte. That byte reports whether the holding buffer can accept a character, whether a frame has fully left the transmitter, and the error and ninth-bit information belonging to the character now at the front of the receive queue.

On the serial side, the block hands the held character to a transmit shift register once that register reports it is idle. A receive deserializer pushes each finished character, together with its frame error, parity error and ninth-bit indications, into the queue. Each queue entry keeps its own flags, so software sees the flags of the character it is about to read. A configuration input selects a character width of 5 to 8 bits. Bits above the selected width are cleared on both the transmit and the receive path.

Top module: `usart_regfront`

## Requirements
- R1: After reset the status byte reads 0x20, a data read returns 0, and `txsr_load` is low. Status bit order, from MSB to LSB, is: receive queue not empty, transmit complete, holding buffer empty, frame error, overflow, parity error, always 0, ninth bit. Address 0 is the data port and address 1 is the status byte.
- R2: A data write while the holding buffer is empty captures the byte, and the buffer-empty bit (bit 5) reads 0 from the next cycle on.
- R3: A data write while the holding buffer is full is discarded, and the held byte is the one later handed to the shift register.
- R4: `txsr_load` is high exactly while the buffer is full, `cfg_tx_en` is high and `txsr_empty` is high. It then presents the held byte on `txsr_data`, and the buffer reads empty from the following cycle on.
- R5: `cfg_char_sz` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Bits above that width are zero in `txsr_data` and in received data reads.
- R6: Received characters are read out in arrival order. The status byte shows the frame error (bit 4), parity error (bit 2) and ninth bit (bit 0) of the front entry only.
- R7: Status bit 7 is 1 exactly when the receive queue holds at least one unread character.
- R8: A character that arrives while both queue entries are full is dropped and sets the overflow bit (bit 3). A data read clears that bit.
- R9: While `cfg_rx_en` is low the queue is empty, the overflow bit is clear, and arriving characters are ignored.
- R10: The transmit-complete bit (bit 6) is set when `txsr_done` pulses while the holding buffer is empty. It stays clear if the buffer is full. Writing a status byte with bit 6 set clears it, and a written 0 in bit 6 leaves it unchanged.
- R11: A data read with an empty queue returns 0 and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 data port, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a data-port read pops the queue |
| bus_rdata | output | 8 | Read data for the selected register |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_rx_en | input | 1 | Receiver enable; low flushes the queue |
| cfg_char_sz | input | 2 | Character width code (0..3 = 5..8 bits) |
| txsr_empty | input | 1 | Transmit shift register is idle |
| txsr_done | input | 1 | One-cycle pulse: a frame finished shifting out |
| txsr_load | output | 1 | Hand held byte to the shift register this cycle |
| txsr_data | output | 8 | Byte offered to the shift register |
| rxd_push | input | 1 | One-cycle pulse: a received character is ready |
| rxd_data | input | 8 | Received character |
| rxd_ferr | input | 1 | Frame error of the received character |
| rxd_perr | input | 1 | Parity error of the received character |
| rxd_bit8 | input | 1 | Ninth data bit of the received character |

## Verification
The assertions assume that `rxd_push` and `txsr_done` are single-cycle pulses and that `cfg_char_sz` does not change while a character is held or queued. The stimulus respects this. It changes configuration only between transactions and drives every input at the falling clock edge. It never combines a data-port read with an arriving character in the same cycle, so the overflow and ordering checks see only one queue event per edge.

// File: rtl/usart_rf_pkg.sv
package usart_rf_pkg;

    localparam int DW = 8;

    // status byte bit positions
    localparam int ST_RXC  = 7;
    localparam int ST_TXC  = 6;
    localparam int ST_DRE  = 5;
    localparam int ST_FERR = 4;
    localparam int ST_OVF  = 3;
    localparam int ST_PERR = 2;
    localparam int ST_BIT8 = 0;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef enum logic [1:0] {
        CSZ_5 = 2'd0,
        CSZ_6 = 2'd1,
        CSZ_7 = 2'd2,
        CSZ_8 = 2'd3
    } char_sz_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          ferr;
        logic          perr;
        logic          bit8;
    } rx_entry_t;

    function automatic logic [DW-1:0] char_mask(logic [1:0] code);
        case (char_sz_e'(code))
            CSZ_5:   return 8'h1F;
            CSZ_6:   return 8'h3F;
            CSZ_7:   return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/usart_txbuf.sv
module usart_txbuf
    import usart_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    char_sz,
    input  logic          tx_en,
    input  logic          sr_empty,
    input  logic          sr_done,
    input  logic          txc_clr,
    output logic          sr_load,
    output logic          buf_full,
    output logic [DW-1:0] buf_data,
    output logic          txc
);

    assign sr_load = buf_full && tx_en && sr_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (sr_load) begin
            buf_full <= 1'b0;
        end else if (wr_en && !buf_full) begin
            buf_full <= 1'b1;
            buf_data <= wr_data & char_mask(char_sz);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            txc <= 1'b0;
        else if (sr_done && !buf_full)
            txc <= 1'b1;
        else if (txc_clr)
            txc <= 1'b0;
    end

endmodule

// File: rtl/usart_rxfifo.sv
module usart_rxfifo
    import usart_rf_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic [1:0]       char_sz,
    input  logic             pop_req,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    rx_entry_t        mem_q [DEPTH];
    rx_entry_t        masked;
    logic             accept, pop, full;

    assign full   = (count == FULL_CNT);
    assign accept = enable && push && !full;
    assign pop    = pop_req && (count != '0);

    always_comb begin
        masked      = push_entry;
        masked.data = push_entry.data & char_mask(char_sz);
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    mem_q[g] <= '0;
                else if (accept && wr_ptr == PTR_W'(g))
                    mem_q[g] <= masked;
            end
        end
    endgenerate

    assign head = mem_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept)
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(accept) - CNT_W'(pop);
            if (push && full)
                ovf <= 1'b1;
            else if (pop_req)
                ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/usart_regfront.sv
module usart_regfront
    import usart_rf_pkg::*;
#(
    parameter int RX_DEPTH = 2,
    parameter int ADDR_W   = 1,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DW-1:0]     bus_rdata,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic [1:0]        cfg_char_sz,
    input  logic              txsr_empty,
    input  logic              txsr_done,
    output logic              txsr_load,
    output logic [DW-1:0]     txsr_data,
    input  logic              rxd_push,
    input  logic [DW-1:0]     rxd_data,
    input  logic              rxd_ferr,
    input  logic              rxd_perr,
    input  logic              rxd_bit8
);

    logic             sel_data, sel_stat;
    logic             tx_full, txc;
    logic [DW-1:0]    tx_data;
    rx_entry_t        rx_in, rx_head, rx_shown;
    logic [CNT_W-1:0] rx_count;
    logic             rx_ovf, rx_any;
    logic [DW-1:0]    status;

    assign sel_data = (bus_addr == ADDR_W'(ADDR_DATA));
    assign sel_stat = (bus_addr == ADDR_W'(ADDR_STAT));

    usart_txbuf u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we && sel_data),
        .wr_data  (bus_wdata),
        .char_sz  (cfg_char_sz),
        .tx_en    (cfg_tx_en),
        .sr_empty (txsr_empty),
        .sr_done  (txsr_done),
        .txc_clr  (bus_we && sel_stat && bus_wdata[ST_TXC]),
        .sr_load  (txsr_load),
        .buf_full (tx_full),
        .buf_data (tx_data),
        .txc      (txc)
    );

    assign txsr_data = tx_data;

    assign rx_in = '{data: rxd_data, ferr: rxd_ferr, perr: rxd_perr, bit8: rxd_bit8};

    usart_rxfifo #(.DEPTH(RX_DEPTH)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg_rx_en),
        .push       (rxd_push),
        .push_entry (rx_in),
        .char_sz    (cfg_char_sz),
        .pop_req    (bus_re && sel_data),
        .head       (rx_head),
        .count      (rx_count),
        .ovf        (rx_ovf)
    );

    assign rx_any   = (rx_count != '0);
    assign rx_shown = rx_any ? rx_head : '0;

    always_comb begin
        status          = '0;
        status[ST_RXC]  = rx_any;
        status[ST_TXC]  = txc;
        status[ST_DRE]  = !tx_full;
        status[ST_FERR] = rx_shown.ferr;
        status[ST_OVF]  = rx_ovf;
        status[ST_PERR] = rx_shown.perr;
        status[ST_BIT8] = rx_shown.bit8;
    end

    assign bus_rdata = sel_stat ? status : rx_shown.data;

endmodule

// File: rtl/usart_regfront_chk.sv
module usart_regfront_chk
    import usart_rf_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DW-1:0]     bus_rdata,
    input logic              cfg_rx_en,
    input logic              rxd_push,
    input logic              txsr_load,
    input logic              tx_full,
    input logic [DW-1:0]     tx_data,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_ovf
);

    logic data_wr, data_rd;
    assign data_wr = bus_we && (bus_addr == ADDR_W'(ADDR_DATA));
    assign data_rd = bus_re && (bus_addr == ADDR_W'(ADDR_DATA));

    a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !tx_full) |=> tx_full);

    a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !txsr_load) |=> (tx_full && $stable(tx_data)));

    a_r4_load_empties: assert property (@(posedge clk) disable iff (rst)
        txsr_load |=> !tx_full);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(DEPTH));

    a_r8_overflow_drop: assert property (@(posedge clk) disable iff (rst)
        (cfg_rx_en && rxd_push && !data_rd && rx_count == CNT_W'(DEPTH))
            |=> (rx_ovf && rx_count == CNT_W'(DEPTH)));

    a_r9_flush: assert property (@(posedge clk) disable iff (rst)
        !cfg_rx_en |=> (rx_count == '0 && !rx_ovf));

    a_r11_empty_read: assert property (@(posedge clk) disable iff (rst)
        (data_rd && rx_count == '0) |-> (bus_rdata == '0));

endmodule

bind usart_regfront usart_regfront_chk #(.DEPTH(RX_DEPTH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .cfg_rx_en (cfg_rx_en),
    .rxd_push  (rxd_push),
    .txsr_load (txsr_load),
    .tx_full   (tx_full),
    .tx_data   (tx_data),
    .rx_count  (rx_count),
    .rx_ovf    (rx_ovf)
);

// File: tb/usart_regfront_tb.sv
module usart_regfront_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [0:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       cfg_tx_en = 1'b0, cfg_rx_en = 1'b0;
    logic [1:0] cfg_char_sz = 2'd3;
    logic       txsr_empty = 1'b0, txsr_done = 1'b0;
    logic       txsr_load;
    logic [7:0] txsr_data;
    logic       rxd_push = 1'b0;
    logic [7:0] rxd_data = '0;
    logic       rxd_ferr = 1'b0, rxd_perr = 1'b0, rxd_bit8 = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usart_regfront dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_char_sz(cfg_char_sz),
        .txsr_empty(txsr_empty), .txsr_done(txsr_done), .txsr_load(txsr_load),
        .txsr_data(txsr_data), .rxd_push(rxd_push), .rxd_data(rxd_data),
        .rxd_ferr(rxd_ferr), .rxd_perr(rxd_perr), .rxd_bit8(rxd_bit8)
    );

    // {size code, written byte, expected byte at shift register}
    localparam logic [17:0] VECS [0:5] = '{
        {2'd0, 8'hFF, 8'h1F},
        {2'd1, 8'hFF, 8'h3F},
        {2'd2, 8'hFF, 8'h7F},
        {2'd3, 8'hFF, 8'hFF},
        {2'd0, 8'hA5, 8'h05},
        {2'd2, 8'hC3, 8'h43}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; bus_re = 1'b1;
        #2;
        d = bus_rdata;
        tick();
        bus_re = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input logic f, input logic p, input logic b);
        rxd_data = d; rxd_ferr = f; rxd_perr = p; rxd_bit8 = b; rxd_push = 1'b1;
        tick();
        rxd_push = 1'b0;
    endtask

    task automatic done_pulse();
        txsr_done = 1'b1;
        tick();
        txsr_done = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // reset state
        rd(1'b1, v); check("R1 status after reset", v, 8'h20);
        rd(1'b0, v); check("R1 data after reset", v, 8'h00);
        check("R1 load idle", {7'd0, txsr_load}, 8'h00);

        // hold, discard, handoff
        wr(1'b0, 8'hA5);
        rd(1'b1, v); check("R2 buffer-empty bit clears", v, 8'h00);
        wr(1'b0, 8'h5A);
        cfg_tx_en = 1'b1; #1;
        check("R4 no load while shifter busy", {7'd0, txsr_load}, 8'h00);
        @(negedge clk);
        txsr_empty = 1'b1; #1;
        check("R4 load when ready", {7'd0, txsr_load}, 8'h01);
        check("R3 dropped write left held byte", txsr_data, 8'hA5);
        tick();
        rd(1'b1, v); check("R4 buffer empty after handoff", v, 8'h20);

        // width masking on transmit
        for (int i = 0; i < 6; i++) begin
            cfg_char_sz = VECS[i][17:16];
            wr(1'b0, VECS[i][15:8]);
            #1;
            check("R4 load per vector", {7'd0, txsr_load}, 8'h01);
            check("R5 transmit width mask", txsr_data, VECS[i][7:0]);
            tick();
        end
        cfg_char_sz = 2'd3;

        // transmit complete
        done_pulse();
        rd(1'b1, v); check("R10 set on done with empty buffer", v, 8'h60);
        rd(1'b0, v); check("R11 empty read returns zero", v, 8'h00);
        rd(1'b1, v); check("R11 empty read keeps flags", v, 8'h60);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R10 zero write keeps flag", v, 8'h60);
        wr(1'b1, 8'h40);
        rd(1'b1, v); check("R10 one write clears flag", v, 8'h20);
        cfg_tx_en = 1'b0;
        wr(1'b0, 8'h11);
        done_pulse();
        rd(1'b1, v); check("R10 not set with full buffer", v, 8'h00);
        cfg_tx_en = 1'b1;
        tick();
        rd(1'b1, v); check("R10 stays clear after drain", v, 8'h20);

        // receive queue
        cfg_rx_en = 1'b1;
        tick();
        push(8'h3C, 1'b1, 1'b0, 1'b1);
        rd(1'b1, v); check("R7 not-empty with front flags", v, 8'hB1);
        push(8'hC3, 1'b0, 1'b1, 1'b0);
        push(8'h77, 1'b0, 1'b0, 1'b0);
        rd(1'b1, v); check("R8 overflow set, front unchanged", v, 8'hB9);
        rd(1'b0, v); check("R6 first character", v, 8'h3C);
        rd(1'b1, v); check("R6 R8 second front flags, overflow cleared", v, 8'hA4);
        rd(1'b0, v); check("R6 second character, third dropped", v, 8'hC3);
        rd(1'b1, v); check("R7 empty after reads", v, 8'h20);
        rd(1'b0, v); check("R11 read of empty queue", v, 8'h00);

        // receive width masking
        cfg_char_sz = 2'd0;
        push(8'hFF, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); check("R5 receive 5-bit mask", v, 8'h1F);
        cfg_char_sz = 2'd2;
        push(8'hFF, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); check("R5 receive 7-bit mask", v, 8'h7F);
        cfg_char_sz = 2'd3;

        // flush
        push(8'h01, 1'b1, 1'b1, 1'b1);
        push(8'h02, 1'b0, 1'b0, 1'b0);
        push(8'h03, 1'b0, 1'b0, 1'b0);
        cfg_rx_en = 1'b0;
        tick();
        rd(1'b1, v); check("R9 flush clears queue and overflow", v, 8'h20);
        push(8'h55, 1'b0, 1'b0, 1'b0);
        cfg_rx_en = 1'b1;
        tick();
        rd(1'b1, v); check("R9 push while disabled ignored", v, 8'h20);
        rd(1'b0, v); check("R9 no data after disabled push", v, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule